// File: doc/BRIEF.md
# SPI Status Register Controller

This block is the serial slave front end of a small nonvolatile memory, limited to the status register path. It takes the serial clock, chip select and serial data pins and brings them into the system clock domain. It decodes an instruction byte in each chip-select frame and carries out three commands: set the write-enable latch, write the status register, and read the status register.

A status write needs the write-enable latch to be set first, and the chip select must end the frame on exactly the sixteenth bit. When those hold, the write starts a self-timed cycle whose length is counted in system clock cycles. During that cycle the busy bit reads 1 and the two protection bits keep their old values. The new protection bits appear only when the cycle finishes, and the write-enable latch is cleared at the same moment. A status read may be issued at any time, including during the busy cycle, so a host can poll for completion.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and spi_miso_oe is low.
- R2: Opcode 0x06 sets the write-enable latch only when chip select rises after exactly 8 clocked bits. With any other bit count the latch is unchanged.
- R3: Opcode 0x05 returns the status byte MSB first. Each bit changes after a falling edge of spi_sck. The byte repeats, freshly sampled, for as long as chip select stays low. The layout is: bit 3 = protect bit 1, bit 2 = protect bit 0, bit 1 = write-enable latch, bit 0 = busy, and bits 7 to 4 read as 0.
- R4: Opcode 0x01 with the write-enable latch clear is ignored: the status byte is unchanged afterwards.
- R5: A status write is carried out only when chip select rises after exactly 16 bits (opcode plus one data byte). With any other bit count the status byte is unchanged.
- R6: An accepted status write holds the busy bit at 1 for WRITE_CYCLES system clocks. When the busy bit returns to 0, the write-enable latch is cleared.
- R7: The protect bits take their new values only when the busy cycle ends. Reads made during the cycle show the old values.
- R8: Only data bits 3 and 2 of a status write are stored. The other data bits have no effect on the status byte.
- R9: While busy, every command other than the status read is ignored.
- R10: spi_miso_oe is high only while a status read is shifting data with chip select low. Otherwise spi_miso is held at 0 and the pad is left in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host (idles low) |
| spi_cs_n | input | 1 | Active-low chip select; a frame begins on its falling edge |
| spi_mosi | input | 1 | Serial data in, sampled on the rising spi_sck edge |
| spi_miso | output | 1 | Serial data out, valid while spi_miso_oe is high |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad driver |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each spi_sck phase and each gap around a chip-select edge must span several system clocks, so that the synchronizers never see a chip-select edge and a clock edge in the same cycle. The stimulus uses half periods of eight system clocks and keeps at least one half period between every chip-select change and the nearest spi_sck edge. Frames that end on the wrong bit count are produced by adding or removing whole clock pulses, never by moving a chip-select edge close to a clock edge.

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [TW-1:0] T_LOAD = TW'(WRITE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sck_q, cs_q, mosi_q;
  logic sck_s, cs_s, mosi_s, sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-2:0], spi_sck};
      cs_q   <= {cs_q[SYNC_STAGES-2:0], spi_cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  assign sck_s  = sck_q[SYNC_STAGES-1];
  assign cs_s   = cs_q[SYNC_STAGES-1];
  assign mosi_s = mosi_q[SYNC_STAGES-1];

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  logic [4:0] bit_cnt;
  logic [7:0] shreg, opcode;
  logic       op_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      opcode  <= '0;
      op_ok   <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      op_ok   <= 1'b0;
    end else if (sck_rise) begin
      shreg <= {shreg[6:0], mosi_s};
      if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
      if (bit_cnt == 5'd7) begin
        opcode <= {shreg[6:0], mosi_s};
        op_ok  <= 1'b1;
      end
    end
  end

  logic          wel, busy;
  logic [1:0]    bp, bp_next;
  logic [TW-1:0] timer;
  logic          wren_go, wrsr_go;

  assign wren_go = cs_rise & ~busy & op_ok & (opcode == OP_WREN) & (bit_cnt == 5'd8);
  assign wrsr_go = cs_rise & ~busy & wel & op_ok & (opcode == OP_WRSR) & (bit_cnt == 5'd16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      busy    <= 1'b0;
      bp      <= '0;
      bp_next <= '0;
      timer   <= '0;
    end else if (wrsr_go) begin
      busy    <= 1'b1;
      timer   <= T_LOAD;
      bp_next <= shreg[3:2];
    end else if (busy) begin
      if (timer == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
        bp   <= bp_next;
      end else begin
        timer <= timer - 1'b1;
      end
    end else if (wren_go) begin
      wel <= 1'b1;
    end
  end

  logic [7:0] status;
  logic [6:0] out_sr;
  logic [2:0] out_pos;
  logic       rd_on, miso_q;

  assign status = {4'b0000, bp, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_on   <= 1'b0;
      out_pos <= '0;
      out_sr  <= '0;
      miso_q  <= 1'b0;
    end else if (cs_s) begin
      rd_on   <= 1'b0;
      out_pos <= '0;
      miso_q  <= 1'b0;
    end else if (sck_fall && op_ok && opcode == OP_RDSR) begin
      rd_on   <= 1'b1;
      out_pos <= out_pos + 3'd1;
      if (out_pos == 3'd0) begin
        miso_q <= status[7];
        out_sr <= status[6:0];
      end else begin
        miso_q <= out_sr[6];
        out_sr <= {out_sr[5:0], 1'b0};
      end
    end
  end

  assign spi_miso_oe = rd_on & ~cs_s;
  assign spi_miso    = spi_miso_oe & miso_q;
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk #(
  parameter int WRITE_CYCLES = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp,
  input logic [7:0] opcode,
  input logic       op_ok,
  input logic       oe
);
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else busy_len <= '0;
  end

  assert_write_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == 32'(WRITE_CYCLES));

  assert_wel_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  assert_bp_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $fell(busy));

  assert_oe_only_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (op_ok && opcode == 8'h05));
endmodule

bind spi_status_ctrl spi_status_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .bp(bp),
  .opcode(opcode), .op_ok(op_ok), .oe(spi_miso_oe)
);

// File: tb/spi_status_ctrl_test.sv
module spi_status_ctrl_test;
  localparam int WC   = 1500;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe;
  int checks = 0, errors = 0, cyc = 0;

  spi_status_ctrl #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] rx);
    rx = '0;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      mosi = w[31-k];
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], miso};
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] d, input int n);
    logic [31:0] rx;
    xfer({op, d, 16'h0}, n, rx);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [31:0] rx;
    xfer({8'h05, 24'h0}, 16, rx);
    s = rx[7:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic [31:0] rx;
    logic [1:0] oldbp;
    int t0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 oe", 16'(miso_oe), 16'h0);
    rdsr(s);
    chk("R1 status", 16'(s), 16'h00);
    chk("R10 oe after read", 16'(miso_oe), 16'h0);

    cmd(8'h01, 8'h0C, 16);
    rdsr(s);
    chk("R4 wrsr without wel", 16'(s), 16'h00);

    for (int n = 0; n <= 20; n++) begin
      if (n == 8) continue;
      cmd(8'h06, 8'h00, n);
      rdsr(s);
      chk($sformatf("R2 wren bits=%0d", n), 16'(s), 16'h00);
    end
    cmd(8'h06, 8'h00, 8);
    rdsr(s);
    chk("R2 wren 8 bits", 16'(s), 16'h02);

    for (int n = 9; n <= 24; n++) begin
      if (n == 16) continue;
      cmd(8'h01, 8'h0C, n);
      rdsr(s);
      chk($sformatf("R5 wrsr bits=%0d", n), 16'(s), 16'h02);
    end

    oldbp = 2'b00;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'(i * 17) ^ 8'(i[1:0] << 2);
      cmd(8'h06, 8'h00, 8);
      cmd(8'h01, d, 16);
      t0 = cyc;
      rdsr(s);
      chk("R7 busy read old bp", 16'(s), 16'({4'b0, oldbp, 2'b11}));
      xfer({8'h05, 24'h0}, 24, rx);
      chk("R3 repeated byte", rx[15:0], {4'b0, oldbp, 2'b11, 4'b0, oldbp, 2'b11});
      chk("R10 oe low after frame", 16'(miso_oe), 16'h0);
      if (i[0]) begin
        cmd(8'h06, 8'h00, 8);
        cmd(8'h01, ~d, 16);
      end
      while (cyc < t0 + WC - 500) @(negedge clk);
      rdsr(s);
      chk("R6 still busy", 16'(s[0]), 16'h1);
      while (cyc < t0 + WC + 60) @(negedge clk);
      rdsr(s);
      chk($sformatf("R8 R9 R6 after cycle d=%h", d), 16'(s), 16'({4'b0, d[3:2], 2'b00}));
      oldbp = d[3:2];
    end

    cmd(8'h06, 8'h00, 8);
    cmd(8'h01, 8'hF3, 16);
    repeat (WC + 100) @(negedge clk);
    xfer({8'h05, 24'h0}, 24, rx);
    chk("R3 R8 idle two bytes", rx[15:0], 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule